// File: doc/BRIEF.md
# Dual-Supply Power-Fail Warning Flags

This block holds the early power-fail warning flags for a device that monitors two supplies. Two comparator outputs, one per supply, report asynchronously that the supply has dropped below its warning threshold. Each input is synchronized and then sets a sticky cause bit for that supply and a shared summary flag. Software sees and changes these flags through two plain register write ports, a status register and a control register. The block also drives a level interrupt request, which is the summary flag gated by an enable bit.

Software may force a warning by writing a 1 to a cause bit. It acknowledges a warning by writing 0 to the summary flag. That acknowledge wipes both cause bits as well. If a warning arrives from the hardware in the same cycle as the acknowledge, the acknowledge is dropped, so no warning is lost. All the interfaces here are control and status pins. None of them carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_warn_flags`

## Requirements
- R1: While a synchronized comparator input is high, the summary flag and that supply's cause bit are set. A comparator input that is raised before clock edge k shows on the outputs after edge k+2 (two synchronizer flops plus the flag register). Supply A maps to `cause_a`, supply B to `cause_b`.
- R2: A status write with bit 3 = 1 sets `cause_a`, and one with bit 2 = 1 sets `cause_b`. The same write also sets the summary flag. Both take effect after the next clock edge.
- R3: Writing 0 to status bit 3 or bit 2 has no effect. A cause bit is never cleared by a status write.
- R4: Control register bit 4 is the summary flag. A control write with bit 4 = 1 sets the flag. A control write with bit 4 = 0 clears the flag and both cause bits together, one edge later.
- R5: If any set source (a synchronized comparator input, or a status write of 1) is active in the same cycle as a clearing control write, the flag stays set and no cause bit is cleared.
- R6: Control register bit 0 is the interrupt enable, loaded on every control write. `pf_irq` equals the summary flag AND the enable.
- R7: An asynchronous active-low reset clears the flag, both cause bits, the enable and the synchronizers to 0.
- R8: The flags are sticky. They stay set after the supply recovers, until software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_a_low | input | 1 | Supply A is below its warning threshold (asynchronous) |
| sup_b_low | input | 1 | Supply B is below its warning threshold (asynchronous) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | DW | Control write data: bit 4 is the summary flag, bit 0 is the interrupt enable |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | DW | Status write data: bit 3 is cause A, bit 2 is cause B |
| pf_flag | output | 1 | Summary power-fail flag |
| cause_a | output | 1 | Supply A cause bit |
| cause_b | output | 1 | Supply B cause bit |
| irq_en | output | 1 | Interrupt enable bit |
| pf_irq | output | 1 | Interrupt request |

## Verification
A register write shows on the outputs one edge after the write strobe is sampled. A comparator input shows three edges after the edge where it is first seen. When an input is released, it keeps setting the flags for two more edges while the synchronizer drains. The driver advances one edge at a time and queues the expected output after each edge. The monitor compares that expectation at the following falling edge, so the latency of every result is checked cycle by cycle. The bench also places a clear exactly in a window where a set is still active, to exercise the priority rule.

// File: rtl/pwr_warn_pkg.sv
package pwr_warn_pkg;
  localparam int CAUSE_A_BIT = 3;
  localparam int CAUSE_B_BIT = 2;
  localparam int PF_BIT      = 4;
  localparam int IE_BIT      = 0;
  localparam int NSUP        = 2;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfw_flags.sv
module pfw_flags
  import pwr_warn_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSUP-1:0] hw_low,
  input  logic            ctrl_wr,
  input  logic [DW-1:0]   ctrl_wdata,
  input  logic            stat_wr,
  input  logic [DW-1:0]   stat_wdata,
  output logic            pf_flag,
  output logic [NSUP-1:0] cause,
  output logic            irq_en
);
  logic [NSUP-1:0] sw_set, cause_set;
  logic pf_set, pf_clr;

  always_comb begin
    sw_set[0] = stat_wr & stat_wdata[CAUSE_A_BIT];
    sw_set[1] = stat_wr & stat_wdata[CAUSE_B_BIT];
    cause_set = hw_low | sw_set;
    pf_set    = (|cause_set) | (ctrl_wr & ctrl_wdata[PF_BIT]);
    pf_clr    = ctrl_wr & ~ctrl_wdata[PF_BIT] & ~pf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_flag <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (pf_set) pf_flag <= 1'b1;
      else if (pf_clr) pf_flag <= 1'b0;
      if (ctrl_wr) irq_en <= ctrl_wdata[IE_BIT];
    end
  end

  for (genvar i = 0; i < NSUP; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause[i] <= 1'b0;
      else if (cause_set[i]) cause[i] <= 1'b1;
      else if (pf_clr) cause[i] <= 1'b0;
    end
  end

  // R1: a synchronized low level sets its cause bit and the summary flag
  a_r1_hw_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    hw_low[0] |=> (pf_flag && cause[0]));
  a_r1_hw_set_b: assert property (@(posedge clk) disable iff (!rst_n)
    hw_low[1] |=> (pf_flag && cause[1]));
  // R2: a status write of 1 sets the cause bit and the flag
  a_r2_sw_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[CAUSE_A_BIT]) |=> (cause[0] && pf_flag));
  // R3: a status write of 0 leaves cause A unchanged
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wdata[CAUSE_A_BIT] && !hw_low[0] && !ctrl_wr) |=> $stable(cause[0]));
  // R4: the flag never falls while a cause bit stays up
  a_r4_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_flag) |-> (cause == '0));
  a_r4_cause_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|cause) |-> pf_flag);
  // R5: a hardware set beats a clearing write in the same cycle
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_wdata[PF_BIT] && (|hw_low)) |=> pf_flag);
endmodule

// File: rtl/pwr_warn_flags.sv
module pwr_warn_flags
  import pwr_warn_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_a_low,
  input  logic          sup_b_low,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] ctrl_wdata,
  input  logic          stat_wr,
  input  logic [DW-1:0] stat_wdata,
  output logic          pf_flag,
  output logic          cause_a,
  output logic          cause_b,
  output logic          irq_en,
  output logic          pf_irq
);
  logic [NSUP-1:0] low_sync, cause;

  pfw_sync #(.W(NSUP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sup_b_low, sup_a_low}), .q(low_sync)
  );

  pfw_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_low(low_sync),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .pf_flag(pf_flag), .cause(cause), .irq_en(irq_en)
  );

  assign cause_a = cause[0];
  assign cause_b = cause[1];
  assign pf_irq  = pf_flag & irq_en;

  // R6: a request needs both the flag and the enable
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pf_irq |-> (pf_flag && irq_en));
endmodule

// File: tb/pwr_warn_flags_tb.sv
module pwr_warn_flags_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sup_a_low = 1'b0, sup_b_low = 1'b0;
  logic ctrl_wr = 1'b0, stat_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0, stat_wdata = '0;
  logic pf_flag, cause_a, cause_b, irq_en, pf_irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] q_val[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  pwr_warn_flags u_dut (
    .clk(clk), .rst_n(rst_n), .sup_a_low(sup_a_low), .sup_b_low(sup_b_low),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .pf_flag(pf_flag), .cause_a(cause_a),
    .cause_b(cause_b), .irq_en(irq_en), .pf_irq(pf_irq)
  );

  function automatic logic [4:0] outs();
    return {pf_flag, cause_a, cause_b, irq_en, pf_irq};
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {flag,ca,cb,en,irq} actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: compares each queued expectation at the following falling edge
  always @(negedge clk) begin
    if (q_val.size() > 0) check(q_tag.pop_front(), outs(), q_val.pop_front());
  end

  task automatic tick();
    @(posedge clk); #1;
    ctrl_wr = 1'b0; stat_wr = 1'b0;
  endtask

  task automatic expect_st(logic f, logic a, logic b, logic en, string tag);
    q_val.push_back({f, a, b, en, f & en});
    q_tag.push_back(tag);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
  endtask

  task automatic wr_stat(logic [7:0] v);
    stat_wr = 1'b1; stat_wdata = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12 rst_n = 1'b1;
    tick(); expect_st(0,0,0,0, "R7 reset state");
    wr_ctrl(8'h01); tick(); expect_st(0,0,0,1, "R6 enable loaded");
    // R1 latency: raised before edge k, visible after edge k+2
    sup_a_low = 1'b1;
    tick(); expect_st(0,0,0,1, "R1 sync stage 1");
    tick(); expect_st(0,0,0,1, "R1 sync stage 2");
    tick(); expect_st(1,1,0,1, "R1 supply A sets flag");
    sup_a_low = 1'b0;
    for (int i = 0; i < 4; i++) begin tick(); expect_st(1,1,0,1, "R8 sticky after recovery"); end
    wr_ctrl(8'h01); tick(); expect_st(0,0,0,1, "R4 clear wipes causes");
    sup_b_low = 1'b1;
    tick(); tick(); tick(); expect_st(1,0,1,1, "R1 supply B sets flag");
    wr_ctrl(8'h01); tick(); expect_st(1,0,1,1, "R5 set wins over clear");
    sup_b_low = 1'b0;
    wr_ctrl(8'h01); tick(); expect_st(1,0,1,1, "R5 drain edge 1");
    wr_ctrl(8'h01); tick(); expect_st(1,0,1,1, "R5 drain edge 2");
    wr_ctrl(8'h01); tick(); expect_st(0,0,0,1, "R4 clear after drain");
    wr_stat(8'h08); tick(); expect_st(1,1,0,1, "R2 write cause A");
    wr_ctrl(8'h01); tick(); expect_st(0,0,0,1, "R4 clear A");
    wr_stat(8'h04); tick(); expect_st(1,0,1,1, "R2 write cause B");
    wr_stat(8'h00); tick(); expect_st(1,0,1,1, "R3 zero write keeps causes");
    wr_stat(8'h08); wr_ctrl(8'h01); tick(); expect_st(1,1,1,1, "R5 status set beats clear");
    wr_ctrl(8'h01); tick(); expect_st(0,0,0,1, "R4 clear both");
    wr_stat(8'hF3); tick(); expect_st(0,0,0,1, "R3 zero bits no effect");
    wr_ctrl(8'h10); tick(); expect_st(1,0,0,0, "R6 flag set, irq masked");
    wr_ctrl(8'h11); tick(); expect_st(1,0,0,1, "R6 irq asserted");
    wr_stat(8'h0C); tick(); expect_st(1,1,1,1, "R2 write both causes");
    @(negedge clk); #1;
    rst_n = 1'b0; #1;
    check("R7 async reset", outs(), 5'b0);
    finish_run();
  end
endmodule